// File: doc/BRIEF.md
# Precise Exception Commit Arbiter

This block sits at the commit point of a simple in-order pipeline. Each cycle it decides which exception, if any, is taken there. The instruction at the head of the pipeline presents its exception tags, sorted by the stage that detected them: fetch-time, decode/execute-time and post-completion. Alongside these the block receives reset requests, machine-check requests and maskable external interrupt requests. When it takes an exception it drives a one-hot take vector, a 5-bit cause code and a one-cycle flush. The pipeline uses the flush to clear every younger tag, so an exception that was dropped can be raised again once its instruction is fetched a second time.

The block also keeps a recoverable-state flag. Taking a reset or a machine check clears the flag. The clean retirement of an instruction sets it again. Fetch-time exceptions are held until the flag is set. Reset and machine check are never held back, not even in the cycle that follows another take. All decisions are registered, so the outputs appear one clock after the inputs that cause them.

Top module: `exc_commit_arb`

## Requirements
- R1: Any of the reset sources (pin, watchdog request, debug request) gives take_o = 4'b0001 and cause_o = 0 one cycle later, regardless of every other input.
- R2: A machine check gives take_o = 4'b0010 and cause_o = 1 one cycle later, unless a reset source is active. Its sources are the machine-check pin, a fault on a handler's first fetch, a buffered-store bus error, the non-maskable pin, and a bus error seen while ext_en=0 and mc_en=1. A bus error under any other combination of ext_en and mc_en is ignored.
- R3: Reset and machine check are taken even in the cycle directly after another take.
- R4: A maskable request is taken only when head_valid=1 and its irq_en bit is set. The lowest enabled index i wins, giving take_o = 4'b0100 and cause_o = 24+i. It ranks below machine check and above every instruction-based exception.
- R5: A fetch tag bit i gives take_o = 4'b1000 and cause_o = 2+i, lowest index first, but only while recov_o=1. While recov_o=0, nothing instruction-based is taken for a fetch-tagged head. A fetch tag outranks execute and post tags.
- R6: An execute tag bit i gives cause_o = 8+i, lowest index first. It is taken whether or not head_done is set, and ranks below fetch tags.
- R7: A post tag bit i gives cause_o = 16+i, but only with head_done=1, the matching post_en bit set, and no fetch or execute tag on the head.
- R8: With redirect=1, the head's fetch, execute and post tags are discarded and not taken. Maskable requests are unaffected.
- R9: At most one take_o bit is set per cycle. flush_o is high in exactly the cycles in which take_o is non-zero.
- R10: In the cycle after a take, maskable requests and instruction-based tags are not taken.
- R11: recov_o is 0 after rst_n. It becomes 0 after a reset or machine-check take. It becomes 1 one cycle after a clean retire: head_valid=1, head_done=1, redirect=0, no take decided, and no flush in progress.
- R12: When nothing is taken, take_o = 0, cause_o = 0 and flush_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| rst_pin | input | 1 | External system reset request |
| wdog_rst | input | 1 | Watchdog reset request |
| dbg_rst | input | 1 | Debug reset request |
| mc_pin | input | 1 | External machine-check request |
| mc_hfetch | input | 1 | Fault on the first fetch of a handler |
| mc_store_be | input | 1 | Bus error on a buffered store |
| mc_bus_err | input | 1 | Bus error, qualified by ext_en and mc_en |
| nmi_pin | input | 1 | Non-maskable interrupt request |
| ext_en | input | 1 | External interrupts enabled |
| mc_en | input | 1 | Machine check enabled |
| irq_req | input | N_IRQ | Maskable interrupt requests |
| irq_en | input | N_IRQ | Per-request enables |
| head_valid | input | 1 | Instruction present at an instruction boundary at the head |
| head_done | input | 1 | Head instruction completes this cycle |
| redirect | input | 1 | An older redirection discards the head |
| ftag | input | N_FETCH | Fetch-time tags of the head |
| etag | input | N_EXEC | Decode/execute-time tags of the head |
| ptag | input | N_POST | Post-completion events of the head |
| post_en | input | N_POST | Post-completion event enables |
| take_o | output | 4 | One-hot take: bit0 reset, bit1 machine check, bit2 interrupt, bit3 instruction |
| cause_o | output | 5 | Cause code of the take |
| flush_o | output | 1 | Flush of younger tags, one cycle per take |
| recov_o | output | 1 | Machine is in a recoverable state |

## Verification
A vector table sets reset, machine-check, interrupt and tag sources against one another. Each entry either pairs two classes, to show which of them ranks higher, or puts a single source against its qualifier (ext_en/mc_en, irq_en, head_done, post_en, redirect), to show the gating. Several entries set more than one bit inside the same class, to confirm that the lowest index wins.

Directed sequences then cover the states that the table cannot hold. A fetch tag right after rst_n shows the recoverable gating. Back-to-back takes show that maskable and instruction-based takes are suppressed while a machine check still gets through. A clean retire after a machine check shows recov_o returning to 1.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int CAUSE_W = 5;
  localparam int TAKE_W  = 4;

  localparam logic [CAUSE_W-1:0] C_RESET      = 5'd0;
  localparam logic [CAUSE_W-1:0] C_MCHK       = 5'd1;
  localparam logic [CAUSE_W-1:0] C_FETCH_BASE = 5'd2;
  localparam logic [CAUSE_W-1:0] C_EXEC_BASE  = 5'd8;
  localparam logic [CAUSE_W-1:0] C_POST_BASE  = 5'd16;
  localparam logic [CAUSE_W-1:0] C_IRQ_BASE   = 5'd24;

  typedef enum logic [1:0] {
    TK_RESET = 2'd0,
    TK_MCHK  = 2'd1,
    TK_IRQ   = 2'd2,
    TK_INSN  = 2'd3
  } take_idx_e;

  typedef struct packed {
    logic               vld;
    logic [CAUSE_W-1:0] cause;
  } pick_t;
endpackage

// File: rtl/exc_first_set.sv
module exc_first_set #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/exc_async_sel.sv
module exc_async_sel (
  input  logic rst_pin,
  input  logic wdog_rst,
  input  logic dbg_rst,
  input  logic mc_pin,
  input  logic mc_hfetch,
  input  logic mc_store_be,
  input  logic mc_bus_err,
  input  logic nmi_pin,
  input  logic ext_en,
  input  logic mc_en,
  output logic rst_hit,
  output logic mc_hit
);
  logic bus_err_q;

  always_comb begin
    rst_hit   = rst_pin | wdog_rst | dbg_rst;
    // a bus error counts as machine check only with interrupts off and checks on
    bus_err_q = mc_bus_err & ~ext_en & mc_en;
    mc_hit    = mc_pin | mc_hfetch | mc_store_be | nmi_pin | bus_err_q;
  end
endmodule

// File: rtl/exc_head_sel.sv
module exc_head_sel
  import exc_arb_pkg::*;
#(
  parameter int N_FETCH = 3,
  parameter int N_EXEC  = 8,
  parameter int N_POST  = 2,
  parameter int N_IRQ   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               head_valid,
  input  logic               head_done,
  input  logic               redirect,
  input  logic               recov,
  input  logic               suppress,
  input  logic [N_FETCH-1:0] ftag,
  input  logic [N_EXEC-1:0]  etag,
  input  logic [N_POST-1:0]  ptag,
  input  logic [N_POST-1:0]  post_en,
  input  logic [N_IRQ-1:0]   irq_req,
  input  logic [N_IRQ-1:0]   irq_en,
  output pick_t              irq_pick,
  output pick_t              insn_pick
);
  localparam int FW = (N_FETCH > 1) ? $clog2(N_FETCH) : 1;
  localparam int EW = (N_EXEC  > 1) ? $clog2(N_EXEC)  : 1;
  localparam int PW = (N_POST  > 1) ? $clog2(N_POST)  : 1;
  localparam int IW = (N_IRQ   > 1) ? $clog2(N_IRQ)   : 1;

  logic          f_any, e_any, p_any, i_any;
  logic [FW-1:0] f_idx;
  logic [EW-1:0] e_idx;
  logic [PW-1:0] p_idx;
  logic [IW-1:0] i_idx;
  logic [N_POST-1:0] post_live;
  logic [N_IRQ-1:0]  irq_live;
  logic          ins_ok;

  assign post_live = ptag & post_en;
  assign irq_live  = irq_req & irq_en;

  exc_first_set #(.N(N_FETCH), .IW(FW)) u_fetch (.req(ftag),      .any(f_any), .idx(f_idx));
  exc_first_set #(.N(N_EXEC),  .IW(EW)) u_exec  (.req(etag),      .any(e_any), .idx(e_idx));
  exc_first_set #(.N(N_POST),  .IW(PW)) u_post  (.req(post_live), .any(p_any), .idx(p_idx));
  exc_first_set #(.N(N_IRQ),   .IW(IW)) u_irq   (.req(irq_live),  .any(i_any), .idx(i_idx));

  always_comb begin
    irq_pick.vld   = head_valid & ~suppress & i_any;
    irq_pick.cause = C_IRQ_BASE + CAUSE_W'(i_idx);

    ins_ok          = head_valid & ~suppress & ~redirect;
    insn_pick.vld   = 1'b0;
    insn_pick.cause = '0;
    if (f_any) begin
      // a fetch-tagged head cannot execute; it waits for a recoverable state
      insn_pick.vld   = ins_ok & recov;
      insn_pick.cause = C_FETCH_BASE + CAUSE_W'(f_idx);
    end else if (e_any) begin
      insn_pick.vld   = ins_ok;
      insn_pick.cause = C_EXEC_BASE + CAUSE_W'(e_idx);
    end else if (p_any) begin
      insn_pick.vld   = ins_ok & head_done;
      insn_pick.cause = C_POST_BASE + CAUSE_W'(p_idx);
    end
  end

  p_fetch_needs_recov_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_pick.vld && (|ftag)) |-> recov);
  p_post_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_pick.vld && !(|ftag) && !(|etag)) |-> (head_done && (|(ptag & post_en))));
  p_redirect_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !insn_pick.vld);
endmodule

// File: rtl/exc_commit_arb.sv
module exc_commit_arb
  import exc_arb_pkg::*;
#(
  parameter int N_FETCH = 3,
  parameter int N_EXEC  = 8,
  parameter int N_POST  = 2,
  parameter int N_IRQ   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_pin,
  input  logic               wdog_rst,
  input  logic               dbg_rst,
  input  logic               mc_pin,
  input  logic               mc_hfetch,
  input  logic               mc_store_be,
  input  logic               mc_bus_err,
  input  logic               nmi_pin,
  input  logic               ext_en,
  input  logic               mc_en,
  input  logic [N_IRQ-1:0]   irq_req,
  input  logic [N_IRQ-1:0]   irq_en,
  input  logic               head_valid,
  input  logic               head_done,
  input  logic               redirect,
  input  logic [N_FETCH-1:0] ftag,
  input  logic [N_EXEC-1:0]  etag,
  input  logic [N_POST-1:0]  ptag,
  input  logic [N_POST-1:0]  post_en,
  output logic [TAKE_W-1:0]  take_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               flush_o,
  output logic               recov_o
);
  logic               rst_hit, mc_hit;
  pick_t              irq_pick, insn_pick;
  logic [TAKE_W-1:0]  take_d, take_q;
  logic [CAUSE_W-1:0] cause_d, cause_q;
  logic               flush_d, flush_q;
  logic               recov_d, recov_q;
  logic               clean_retire;

  exc_async_sel u_async (
    .rst_pin(rst_pin), .wdog_rst(wdog_rst), .dbg_rst(dbg_rst),
    .mc_pin(mc_pin), .mc_hfetch(mc_hfetch), .mc_store_be(mc_store_be),
    .mc_bus_err(mc_bus_err), .nmi_pin(nmi_pin), .ext_en(ext_en), .mc_en(mc_en),
    .rst_hit(rst_hit), .mc_hit(mc_hit)
  );

  exc_head_sel #(.N_FETCH(N_FETCH), .N_EXEC(N_EXEC), .N_POST(N_POST), .N_IRQ(N_IRQ)) u_head (
    .clk(clk), .rst_n(rst_n),
    .head_valid(head_valid), .head_done(head_done), .redirect(redirect),
    .recov(recov_q), .suppress(flush_q),
    .ftag(ftag), .etag(etag), .ptag(ptag), .post_en(post_en),
    .irq_req(irq_req), .irq_en(irq_en),
    .irq_pick(irq_pick), .insn_pick(insn_pick)
  );

  // next-state decision
  always_comb begin
    take_d  = '0;
    cause_d = '0;
    if (rst_hit) begin
      take_d[TK_RESET] = 1'b1;
      cause_d          = C_RESET;
    end else if (mc_hit) begin
      take_d[TK_MCHK] = 1'b1;
      cause_d         = C_MCHK;
    end else if (irq_pick.vld) begin
      take_d[TK_IRQ] = 1'b1;
      cause_d        = irq_pick.cause;
    end else if (insn_pick.vld) begin
      take_d[TK_INSN] = 1'b1;
      cause_d         = insn_pick.cause;
    end
    flush_d = rst_hit | mc_hit | irq_pick.vld | insn_pick.vld;

    clean_retire = head_valid & head_done & ~redirect & ~flush_q & ~flush_d;
    recov_d      = recov_q;
    if (rst_hit || mc_hit) recov_d = 1'b0;
    else if (clean_retire) recov_d = 1'b1;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q  <= '0;
      cause_q <= '0;
      flush_q <= 1'b0;
      recov_q <= 1'b0;
    end else begin
      take_q  <= take_d;
      cause_q <= cause_d;
      flush_q <= flush_d;
      recov_q <= recov_d;
    end
  end

  assign take_o  = take_q;
  assign cause_o = cause_q;
  assign flush_o = flush_q;
  assign recov_o = recov_q;

  p_onehot_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_o));
  p_flush_tracks_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o == (take_o != '0));
  p_reset_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pin || wdog_rst || dbg_rst) |=> (take_o == 4'b0001 && cause_o == C_RESET));
  p_mchk_not_delayed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_hit && !rst_hit) |=> (take_o == 4'b0010 && cause_o == C_MCHK));
  p_suppress_after_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (!take_o[TK_IRQ] && !take_o[TK_INSN]));
  p_recov_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o[TK_RESET] || take_o[TK_MCHK]) |-> !recov_o);
  p_idle_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o == '0) |-> (cause_o == '0));
endmodule

// File: tb/sim_exc_commit_arb.sv
`timescale 1ns/1ps
module sim_exc_commit_arb;
  logic clk = 1'b0;
  logic rst_n;
  logic rst_pin, wdog_rst, dbg_rst, mc_pin, mc_hfetch, mc_store_be, mc_bus_err, nmi_pin;
  logic ext_en, mc_en, head_valid, head_done, redirect;
  logic [3:0] irq_req, irq_en;
  logic [2:0] ftag;
  logic [7:0] etag;
  logic [1:0] ptag, post_en;
  logic [3:0] take_o;
  logic [4:0] cause_o;
  logic       flush_o, recov_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  exc_commit_arb u0 (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .wdog_rst(wdog_rst), .dbg_rst(dbg_rst),
    .mc_pin(mc_pin), .mc_hfetch(mc_hfetch), .mc_store_be(mc_store_be), .mc_bus_err(mc_bus_err),
    .nmi_pin(nmi_pin), .ext_en(ext_en), .mc_en(mc_en), .irq_req(irq_req), .irq_en(irq_en),
    .head_valid(head_valid), .head_done(head_done), .redirect(redirect),
    .ftag(ftag), .etag(etag), .ptag(ptag), .post_en(post_en),
    .take_o(take_o), .cause_o(cause_o), .flush_o(flush_o), .recov_o(recov_o)
  );

  // rsts = {dbg, wdog, pin}; mcs = {bus_err, store_be, hfetch, pin}
  typedef struct packed {
    logic [2:0] rsts;
    logic [3:0] mcs;
    logic       nmi, ee, me;
    logic [3:0] irq, irqen;
    logic       hv, hd, rd;
    logic [2:0] ft;
    logic [7:0] et;
    logic [1:0] pt, pe;
    logic [3:0] etake;
    logic [4:0] ecause;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{3'b000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 3'b000, 8'h00, 2'b00, 2'b00, 4'b0000, 5'd0 },  // R12
    '{3'b010, 4'b0001, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 3'b000, 8'h01, 2'b00, 2'b00, 4'b0001, 5'd0 },  // R1
    '{3'b100, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 3'b000, 8'h00, 2'b00, 2'b00, 4'b0001, 5'd0 },  // R1
    '{3'b000, 4'b0100, 1'b0, 1'b0, 1'b0, 4'b0001, 4'b0001, 1'b1, 1'b0, 1'b0, 3'b000, 8'h00, 2'b00, 2'b00, 4'b0010, 5'd1 },  // R2
    '{3'b000, 4'b1000, 1'b0, 1'b0, 1'b1, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 3'b000, 8'h00, 2'b00, 2'b00, 4'b0010, 5'd1 },  // R2
    '{3'b000, 4'b1000, 1'b0, 1'b1, 1'b1, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 3'b000, 8'h00, 2'b00, 2'b00, 4'b0000, 5'd0 },  // R2
    '{3'b000, 4'b1000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 3'b000, 8'h00, 2'b00, 2'b00, 4'b0000, 5'd0 },  // R2
    '{3'b000, 4'b0000, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 3'b000, 8'h00, 2'b00, 2'b00, 4'b0010, 5'd1 },  // R2
    '{3'b000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0110, 4'b0100, 1'b1, 1'b0, 1'b0, 3'b000, 8'h01, 2'b00, 2'b00, 4'b0100, 5'd26},  // R4
    '{3'b000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0001, 4'b0000, 1'b1, 1'b0, 1'b0, 3'b010, 8'h00, 2'b00, 2'b00, 4'b1000, 5'd3 },  // R5
    '{3'b000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0001, 4'b0001, 1'b0, 1'b0, 1'b0, 3'b000, 8'h00, 2'b00, 2'b00, 4'b0000, 5'd0 },  // R4
    '{3'b000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 3'b100, 8'h01, 2'b00, 2'b00, 4'b1000, 5'd4 },  // R5
    '{3'b000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 3'b000, 8'h28, 2'b00, 2'b00, 4'b1000, 5'd11},  // R6
    '{3'b000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 3'b000, 8'h80, 2'b00, 2'b00, 4'b1000, 5'd15},  // R6
    '{3'b000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 3'b000, 8'h00, 2'b11, 2'b10, 4'b1000, 5'd17},  // R7
    '{3'b000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 3'b000, 8'h00, 2'b01, 2'b01, 4'b0000, 5'd0 },  // R7
    '{3'b000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 3'b000, 8'h01, 2'b01, 2'b01, 4'b1000, 5'd8 },  // R7
    '{3'b000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 3'b000, 8'h00, 2'b11, 2'b00, 4'b0000, 5'd0 },  // R7
    '{3'b000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b1, 3'b000, 8'h01, 2'b00, 2'b00, 4'b0000, 5'd0 },  // R8
    '{3'b000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0001, 4'b0001, 1'b1, 1'b0, 1'b1, 3'b001, 8'h01, 2'b00, 2'b00, 4'b0100, 5'd24},  // R8
    '{3'b001, 4'b0010, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 3'b000, 8'h00, 2'b00, 2'b00, 4'b0001, 5'd0 }   // R1
  };

  task automatic drive(input vec_t v);
    {dbg_rst, wdog_rst, rst_pin}              = v.rsts;
    {mc_bus_err, mc_store_be, mc_hfetch, mc_pin} = v.mcs;
    nmi_pin = v.nmi; ext_en = v.ee; mc_en = v.me;
    irq_req = v.irq; irq_en = v.irqen;
    head_valid = v.hv; head_done = v.hd; redirect = v.rd;
    ftag = v.ft; etag = v.et; ptag = v.pt; post_en = v.pe;
  endtask

  function automatic vec_t quiet();
    vec_t v = '0;
    return v;
  endfunction

  function automatic vec_t retire();
    vec_t v = '0;
    v.hv = 1'b1; v.hd = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a vector at a falling edge, sample the registered result at the next falling edge
  task automatic cyc(input vec_t v);
    drive(v);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(quiet());
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11/R12 reset state
    chk("R12 take after reset", int'(take_o), 0);
    chk("R12 cause after reset", int'(cause_o), 0);
    chk("R12 flush after reset", int'(flush_o), 0);
    chk("R11 recov after reset", int'(recov_o), 0);

    // R5: fetch tag while not recoverable is held, together with an exec tag
    begin
      vec_t v = quiet();
      v.hv = 1'b1; v.ft = 3'b001; v.et = 8'h01;
      cyc(v);
      chk("R5 fetch held while unrecoverable", int'(take_o), 0);
    end

    // vector table
    for (int k = 0; k < NV; k++) begin
      cyc(retire());
      cyc(VEC[k]);
      chk($sformatf("vec%0d take", k), int'(take_o), int'(VEC[k].etake));
      chk($sformatf("vec%0d cause", k), int'(cause_o), int'(VEC[k].ecause));
      chk($sformatf("R9 vec%0d flush", k), int'(flush_o), int'(VEC[k].etake != 4'b0000));
      chk($sformatf("R11 vec%0d recov", k), int'(recov_o),
          int'(VEC[k].etake[1:0] == 2'b00));
      cyc(quiet());
      chk($sformatf("R9 vec%0d flush drops", k), int'(flush_o), 0);
    end

    // R10: after a take, irq and instruction tags are suppressed for one cycle
    cyc(retire());
    begin
      vec_t v = quiet();
      v.hv = 1'b1; v.et = 8'h02;
      cyc(v);
      chk("R6 first exec take", int'(cause_o), 9);
      v.irq = 4'b0001; v.irqen = 4'b0001;
      cyc(v);
      chk("R10 suppressed take", int'(take_o), 0);
      chk("R10 suppressed flush", int'(flush_o), 0);
      cyc(v);
      chk("R4 irq after suppression", int'(cause_o), 24);
    end

    // R3: machine check in the cycle after a take is not delayed
    cyc(quiet());
    begin
      vec_t v = quiet();
      v.hv = 1'b1; v.et = 8'h01;
      cyc(v);
      chk("R3 prior take", int'(take_o), 8);
      v.mcs = 4'b0001;
      cyc(v);
      chk("R3 mchk not delayed", int'(take_o), 2);
      chk("R3 mchk cause", int'(cause_o), 1);
      chk("R11 recov cleared by mchk", int'(recov_o), 0);
    end
    cyc(quiet());
    cyc(retire());
    chk("R11 recov set by clean retire", int'(recov_o), 1);
    begin
      vec_t v = quiet();
      v.rsts = 3'b001;
      cyc(v);
      chk("R3 reset take", int'(take_o), 1);
      v.rsts = 3'b000; v.mcs = 4'b0010;
      cyc(v);
      chk("R3 mchk right after reset take", int'(take_o), 2);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule